// File: doc/BRIEF.md
# Embedded-Clock Word Serializer with Sync Burst Generator

This block turns a parallel data word into a serial frame that carries its own clock marker. Every frame has a fixed high leading bit, the data bits least-significant first, and a fixed low trailing bit, so a frame is two slots longer than the data word. The block runs on a fast clock. A bit-slot strobe steps the output through the frame slots, and the last slot of each frame marks a word boundary. Parallel data is captured from a separate word-clock input, on the edge that a select input chooses.

Two link-training request inputs are combined with OR. Once the combined request has been seen high at enough consecutive word boundaries, the block replaces data frames with a fixed-length burst of training words. Each training word is a run of ones followed by a run of zeros, one half-frame each. A burst cannot be restarted while it runs. If the request is still qualified when a burst ends, the next burst follows at once with no data words in between.

An output-enable input and a power-up input gate the line. The line is flagged undriven (the high-impedance state) whenever either input is low. It is also undriven for a fixed number of words while the link initializes after power-up. A status output shows when a training burst is in progress.

Top module: `esr_serializer`

## Requirements
- R1: Either request input alone is enough to start a training burst; the two inputs are combined with OR.
- R2: A burst begins in the word that follows the QUAL_WORDS-th consecutive word boundary (default 6) at which the combined request was sampled high. QUAL_WORDS-1 high samples followed by a low sample start nothing.
- R3: A burst lasts exactly BURST_WORDS words (default 1026), whether or not the request stays high, and a request that rises during a burst does not lengthen it.
- R4: A training word drives 1 in slots 0 to 5 and 0 in slots 6 to 11 of the frame, and sync_busy is high for every word of a burst.
- R5: The qualifying count continues through burst words. If the last QUAL_WORDS boundaries before a burst ends were all sampled high, the next burst starts in the following word. Otherwise data words are sent until the count completes.
- R6: Parallel data presented during a burst does not appear on the line. The first data word after a burst carries the word captured during the last burst word.
- R7: A data frame drives 1 in slot 0, data bit i in slot i+1 (bit 0 first), and 0 in slot 11. The word sent is the one captured during the previous word.
- R8: ser_oe is high only while out_en and pwr_up are both high and the link is past initialization. While ser_oe is low, ser_out is 0.
- R9: With edge_rise high, din is captured on a rising edge of word_clk. With edge_rise low, it is captured on a falling edge.
- R10: Taking pwr_up low ends any burst and clears sync_busy. After pwr_up returns high, INIT_WORDS words (default 1026) pass with the line undriven before data is sent.
- R11: Taking out_en low and back high changes neither the word sequence nor the length of a burst in progress. sync_busy is unaffected by out_en.
- R12: Reset leaves the line undriven with ser_out and sync_busy low. The frame slot advances only on cycles where bit_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-slot strobe; one slot is sent per strobe |
| word_clk | input | 1 | Parallel word clock, sampled on clk |
| edge_rise | input | 1 | Capture edge for din: 1 rising, 0 falling |
| din | input | DATA_W | Parallel data word |
| sync_req_a | input | 1 | Link-training request, first source |
| sync_req_b | input | 1 | Link-training request, second source |
| out_en | input | 1 | Line driver enable |
| pwr_up | input | 1 | High to operate, low for power-down |
| ser_out | output | 1 | Serial line bit |
| ser_oe | output | 1 | Line driven flag; low stands for high impedance |
| sync_busy | output | 1 | High during a training burst |

## Verification
Data frames are exercised with walking-one words paired with their complements on the opposite half of the word clock, plus all-ones, all-zeros and alternating patterns. A slot-order or capture-edge error therefore shows as a specific wrong frame. Request patterns cover a hold one boundary short of qualification, an exact qualifying hold on each input, a continuous hold across two bursts, and a request that rises late inside a burst. Together these separate the qualifier, the non-retrigger rule and the back-to-back rule. Output-enable drops during data and during a burst, a gapped bit strobe, and a power-down in the middle of a burst show that gating and stepping leave the word and burst counts intact, while power-down clears them.

// File: rtl/esr_pkg.sv
`timescale 1ns/1ps
package esr_pkg;

    typedef enum logic [1:0] {
        LINK_OFF  = 2'd0,
        LINK_INIT = 2'd1,
        LINK_DATA = 2'd2,
        LINK_SYNC = 2'd3
    } link_mode_e;

    typedef struct packed {
        logic drive;
        logic level;
        logic busy;
    } line_t;

    function automatic int frame_slots(input int data_w);
        return data_w + 2;
    endfunction

    function automatic int count_width(input int a, input int b);
        int top;
        top = (a > b) ? a : b;
        return $clog2(top + 1);
    endfunction

    function automatic logic link_live(input link_mode_e m);
        return (m == LINK_DATA) || (m == LINK_SYNC);
    endfunction

endpackage

// File: rtl/esr_word_timer.sv
`timescale 1ns/1ps
module esr_word_timer #(
    parameter int NSLOT = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic                     bit_en,
    output logic [$clog2(NSLOT)-1:0] slot,
    output logic                     word_tick
);
    localparam int SW = $clog2(NSLOT);
    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            slot <= '0;
        end else if (bit_en) begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    assign word_tick = run && bit_en && (slot == LAST);

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && run) |=> (slot == $past(slot)))
        else $error("slot moved without bit strobe"); // R12

endmodule

// File: rtl/esr_link_ctl.sv
`timescale 1ns/1ps
module esr_link_ctl
    import esr_pkg::*;
#(
    parameter int QUAL_WORDS  = 6,
    parameter int BURST_WORDS = 1026,
    parameter int INIT_WORDS  = 1026
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_up,
    input  logic       req_any,
    input  logic       word_tick,
    output link_mode_e mode
);
    localparam int CW = count_width(BURST_WORDS, INIT_WORDS);
    localparam int QW = $clog2(QUAL_WORDS + 1);
    localparam logic [CW-1:0] INIT_LAST  = CW'(INIT_WORDS - 1);
    localparam logic [CW-1:0] BURST_LAST = CW'(BURST_WORDS - 1);
    localparam logic [QW-1:0] QUAL_FULL  = QW'(QUAL_WORDS);

    logic [CW-1:0] cnt;
    logic [QW-1:0] qual;
    logic [QW-1:0] qual_nxt;
    logic          qualified;

    always_comb begin
        if (!req_any)
            qual_nxt = '0;
        else if (qual == QUAL_FULL)
            qual_nxt = qual;
        else
            qual_nxt = qual + 1'b1;
        qualified = (qual_nxt == QUAL_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_up) begin
            mode <= LINK_OFF;
            cnt  <= '0;
            qual <= '0;
        end else begin
            case (mode)
                LINK_OFF: begin
                    mode <= LINK_INIT;
                    cnt  <= '0;
                    qual <= '0;
                end
                LINK_INIT: begin
                    if (word_tick) begin
                        qual <= qual_nxt;
                        if (cnt == INIT_LAST) begin
                            cnt  <= '0;
                            mode <= qualified ? LINK_SYNC : LINK_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                LINK_DATA: begin
                    if (word_tick) begin
                        qual <= qual_nxt;
                        if (qualified) begin
                            mode <= LINK_SYNC;
                            cnt  <= '0;
                        end
                    end
                end
                LINK_SYNC: begin
                    if (word_tick) begin
                        qual <= qual_nxt;
                        if (cnt == BURST_LAST) begin
                            cnt  <= '0;
                            mode <= qualified ? LINK_SYNC : LINK_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: mode <= LINK_OFF;
            endcase
        end
    end

    AST_BURST_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (mode == LINK_SYNC && $past(mode) != LINK_SYNC) |-> $past(req_any))
        else $error("burst began without request"); // R2

    AST_BURST_FULL: assert property (@(posedge clk) disable iff (rst)
        (mode != LINK_SYNC && $past(mode) == LINK_SYNC && $past(pwr_up))
            |-> ($past(cnt) == BURST_LAST))
        else $error("burst ended early"); // R3

endmodule

// File: rtl/esr_data_latch.sv
`timescale 1ns/1ps
module esr_data_latch #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_clk,
    input  logic              edge_rise,
    input  logic [DATA_W-1:0] din,
    input  logic              word_tick,
    output logic [DATA_W-1:0] cur_word
);
    logic              wclk_q;
    logic              strobe;
    logic [DATA_W-1:0] hold;

    assign strobe = edge_rise ? (word_clk & ~wclk_q) : (~word_clk & wclk_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            wclk_q   <= 1'b0;
            hold     <= '0;
            cur_word <= '0;
        end else begin
            wclk_q <= word_clk;
            if (strobe)
                hold <= din;
            if (word_tick)
                cur_word <= hold;
        end
    end

endmodule

// File: rtl/esr_frame_build.sv
`timescale 1ns/1ps
module esr_frame_build
    import esr_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  link_mode_e                                  mode,
    input  logic [$clog2(frame_slots(DATA_W))-1:0]      slot,
    input  logic [DATA_W-1:0]                           word,
    output logic                                        level
);
    localparam int NSLOT = frame_slots(DATA_W);

    logic [NSLOT-1:0] data_frame;
    logic [NSLOT-1:0] sync_frame;

    assign data_frame[0]       = 1'b1;
    assign data_frame[NSLOT-1] = 1'b0;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_data
            assign data_frame[i+1] = word[i];
        end
        for (genvar j = 0; j < NSLOT; j++) begin : g_sync
            assign sync_frame[j] = (j < NSLOT / 2);
        end
    endgenerate

    assign level = (mode == LINK_SYNC) ? sync_frame[slot] : data_frame[slot];

endmodule

// File: rtl/esr_serializer.sv
`timescale 1ns/1ps
module esr_serializer
    import esr_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int QUAL_WORDS  = 6,
    parameter int BURST_WORDS = 1026,
    parameter int INIT_WORDS  = 1026
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              word_clk,
    input  logic              edge_rise,
    input  logic [DATA_W-1:0] din,
    input  logic              sync_req_a,
    input  logic              sync_req_b,
    input  logic              out_en,
    input  logic              pwr_up,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              sync_busy
);
    localparam int NSLOT = frame_slots(DATA_W);
    localparam int SW    = $clog2(NSLOT);
    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    link_mode_e        mode;
    logic [SW-1:0]     slot;
    logic              word_tick;
    logic [DATA_W-1:0] cur_word;
    logic              level;
    logic              req_any;
    line_t             line;

    assign req_any = sync_req_a | sync_req_b;

    esr_word_timer #(.NSLOT(NSLOT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (mode != LINK_OFF),
        .bit_en    (bit_en),
        .slot      (slot),
        .word_tick (word_tick)
    );

    esr_link_ctl #(
        .QUAL_WORDS  (QUAL_WORDS),
        .BURST_WORDS (BURST_WORDS),
        .INIT_WORDS  (INIT_WORDS)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .pwr_up    (pwr_up),
        .req_any   (req_any),
        .word_tick (word_tick),
        .mode      (mode)
    );

    esr_data_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .word_clk  (word_clk),
        .edge_rise (edge_rise),
        .din       (din),
        .word_tick (word_tick),
        .cur_word  (cur_word)
    );

    esr_frame_build #(.DATA_W(DATA_W)) u_frame (
        .mode  (mode),
        .slot  (slot),
        .word  (cur_word),
        .level (level)
    );

    always_comb begin
        line.drive = out_en & pwr_up & link_live(mode);
        line.level = line.drive & level;
        line.busy  = (mode == LINK_SYNC);
    end

    assign ser_out   = line.level;
    assign ser_oe    = line.drive;
    assign sync_busy = line.busy;

    AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
        (ser_oe && !sync_busy && slot == '0) |-> ser_out)
        else $error("data frame lacks leading one"); // R7

    AST_STOP_BIT: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST) |-> !ser_out)
        else $error("frame lacks trailing zero"); // R7

    AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pwr_up |=> !sync_busy)
        else $error("burst survives power-down"); // R10

    AST_WAKE_DARK: assert property (@(posedge clk) disable iff (rst)
        (pwr_up && !$past(pwr_up)) |-> !ser_oe)
        else $error("line driven on wake"); // R10

endmodule

// File: tb/esr_serializer_test.sv
`timescale 1ns/1ps
module esr_serializer_test;
    localparam int DW = 10;
    localparam int NS = DW + 2;
    localparam int QW = 6;
    localparam int BL = 8;
    localparam int IL = 4;
    localparam logic [NS-1:0] SYNC_FRAME = {{(NS/2){1'b0}}, {(NS/2){1'b1}}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_en = 1'b0;
    logic          word_clk = 1'b0;
    logic          edge_rise = 1'b1;
    logic [DW-1:0] din = '0;
    logic          sync_req_a = 1'b0;
    logic          sync_req_b = 1'b0;
    logic          out_en = 1'b1;
    logic          pwr_up = 1'b1;
    wire           ser_out;
    wire           ser_oe;
    wire           sync_busy;

    esr_serializer #(
        .DATA_W(DW), .QUAL_WORDS(QW), .BURST_WORDS(BL), .INIT_WORDS(IL)
    ) uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .word_clk(word_clk),
        .edge_rise(edge_rise), .din(din), .sync_req_a(sync_req_a),
        .sync_req_b(sync_req_b), .out_en(out_en), .pwr_up(pwr_up),
        .ser_out(ser_out), .ser_oe(ser_oe), .sync_busy(sync_busy)
    );

    always #2.5 clk = ~clk;

    int            checks = 0;
    int            errors = 0;
    logic [DW-1:0] pending = '0;
    bit            gap_mode = 1'b0;
    logic [NS-1:0] cap;
    logic          oe_all, oe_any, busy_all, busy_any;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] data_frame(input logic [DW-1:0] d);
        return {1'b0, d, 1'b1};
    endfunction

    task automatic run_word(input logic [DW-1:0] a, input logic [DW-1:0] b);
        oe_all = 1'b1; oe_any = 1'b0; busy_all = 1'b1; busy_any = 1'b0;
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            word_clk = (s < NS/2);
            din = (s < NS/2) ? a : b;
            if (gap_mode) begin
                bit_en = 1'b0;
                @(negedge clk);
            end
            bit_en = 1'b1;
            #1;
            cap[s]   = ser_out;
            oe_all   = oe_all & ser_oe;
            oe_any   = oe_any | ser_oe;
            busy_all = busy_all & sync_busy;
            busy_any = busy_any | sync_busy;
        end
        @(posedge clk);
        #0.5;
        bit_en = 1'b0;
        pending = edge_rise ? a : b;
    endtask

    task automatic w_data(input logic [DW-1:0] a, input logic [DW-1:0] b, input string req);
        logic [NS-1:0] exp;
        exp = data_frame(pending);
        run_word(a, b);
        check(cap == exp && oe_all && !busy_any, req,
              {oe_all, oe_any, busy_all, busy_any, cap}, {4'b1100, exp});
    endtask

    task automatic w_sync(input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input bit oe_exp, input string req);
        logic [NS-1:0] exp;
        exp = oe_exp ? SYNC_FRAME : '0;
        run_word(a, b);
        check(cap == exp && oe_all == oe_exp && oe_any == oe_exp && busy_all, req,
              {oe_all, oe_any, busy_all, busy_any, cap}, {oe_exp, oe_exp, 2'b11, exp});
    endtask

    task automatic w_dark(input logic [DW-1:0] a, input logic [DW-1:0] b, input string req);
        run_word(a, b);
        check(cap == '0 && !oe_any && !busy_any, req,
              {oe_all, oe_any, busy_all, busy_any, cap}, 16'h0000);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog R12 actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        // R12: reset state
        check({ser_oe, ser_out, sync_busy} == 3'b000, "R12 reset",
              {ser_oe, ser_out, sync_busy}, 0);
        rst = 1'b0;

        // R10: initialization words are dark
        for (int i = 0; i < IL; i++) w_dark(DW'(i + 3), DW'(i + 40), "R10 init");

        // R7 R9: walking ones with complements, rising capture
        for (int i = 0; i < DW; i++) w_data(DW'(1) << i, ~(DW'(1) << i), "R7 R9 rise walk");
        w_data('1, '0, "R7 all ones");
        w_data('0, '1, "R7 all zeros");
        w_data(10'h155, 10'h2AA, "R7 alternating");
        w_data(10'h2AA, 10'h155, "R7 alternating");

        // R9: falling capture
        edge_rise = 1'b0;
        for (int i = 0; i < 8; i++) w_data(DW'(i * 37), DW'(i * 91 + 5), "R9 fall");
        edge_rise = 1'b1;
        w_data(10'h0F0, 10'h00F, "R9 back to rise");
        w_data(10'h333, 10'h0CC, "R9 rise");

        // R2: one boundary short of qualifying
        sync_req_a = 1'b1;
        for (int i = 0; i < QW - 1; i++) w_data(DW'(i + 100), DW'(i), "R2 short hold");
        sync_req_a = 1'b0;
        for (int i = 0; i < 3; i++) w_data(DW'(i + 200), DW'(i), "R2 no burst");

        // R1 R3 R4 R6: exact hold on second input, burst ignores data
        sync_req_b = 1'b1;
        for (int i = 0; i < QW; i++) w_data(DW'(i + 300), DW'(i), "R1 qualifying");
        sync_req_b = 1'b0;
        for (int i = 0; i < BL; i++) w_sync(DW'(i * 59 + 1), DW'(i * 13), 1'b1, "R3 R4 R6 burst");
        w_data(10'h1C3, 10'h23C, "R6 first data after burst");
        w_data(10'h011, 10'h3EE, "R3 burst length");

        // R5: continuous hold on first input gives back-to-back bursts
        sync_req_a = 1'b1;
        for (int i = 0; i < QW; i++) w_data(DW'(i + 400), DW'(i), "R1 R5 qualifying");
        for (int i = 0; i < 10; i++) w_sync(DW'(i), DW'(i + 1), 1'b1, "R5 back to back");
        sync_req_a = 1'b0;
        for (int i = 0; i < 2 * BL - 10; i++) w_sync(DW'(i), DW'(i + 2), 1'b1, "R5 second burst");
        w_data(10'h2F1, 10'h10E, "R5 data after pair");
        w_data(10'h0AB, 10'h354, "R5 data after pair");

        // R3 R5: request rising late in a burst does not extend it
        sync_req_a = 1'b1;
        for (int i = 0; i < QW; i++) w_data(DW'(i + 500), DW'(i), "R5 qualifying");
        sync_req_a = 1'b0;
        for (int i = 0; i < BL - 3; i++) w_sync(DW'(i), DW'(i), 1'b1, "R3 burst");
        sync_req_a = 1'b1;
        for (int i = 0; i < 3; i++) w_sync(DW'(i), DW'(i), 1'b1, "R3 no retrigger");
        for (int i = 0; i < 3; i++) w_data(DW'(i + 600), DW'(i + 7), "R5 gap words");
        sync_req_a = 1'b0;
        for (int i = 0; i < BL; i++) w_sync(DW'(i), DW'(i), 1'b1, "R5 late burst");
        w_data(10'h3C3, 10'h03C, "R5 data after late burst");

        // R8 R11: output enable during data and during a burst
        out_en = 1'b0;
        for (int i = 0; i < 3; i++) w_dark(DW'(i + 700), DW'(i), "R8 out_en low");
        out_en = 1'b1;
        w_data(10'h155, 10'h0AA, "R11 resume data");
        w_data(10'h2A0, 10'h05F, "R11 resume data");
        sync_req_b = 1'b1;
        for (int i = 0; i < QW; i++) w_data(DW'(i + 800), DW'(i), "R11 qualifying");
        sync_req_b = 1'b0;
        for (int i = 0; i < 2; i++) w_sync(DW'(i), DW'(i), 1'b1, "R11 burst");
        out_en = 1'b0;
        for (int i = 0; i < 3; i++) w_sync(DW'(i), DW'(i), 1'b0, "R8 R11 burst undriven");
        out_en = 1'b1;
        for (int i = 0; i < BL - 5; i++) w_sync(DW'(i), DW'(i), 1'b1, "R11 burst resumes");
        w_data(10'h1E1, 10'h21E, "R11 burst length kept");

        // R12: gapped bit strobe
        gap_mode = 1'b1;
        for (int i = 0; i < 4; i++) w_data(DW'(i * 211 + 9), DW'(i * 3), "R12 gapped strobe");
        gap_mode = 1'b0;

        // R10: power-down in the middle of a burst
        sync_req_a = 1'b1;
        for (int i = 0; i < QW; i++) w_data(DW'(i + 900), DW'(i), "R10 qualifying");
        sync_req_a = 1'b0;
        for (int i = 0; i < 3; i++) w_sync(DW'(i), DW'(i), 1'b1, "R10 burst");
        @(negedge clk);
        pwr_up = 1'b0;
        #1;
        check(ser_oe == 1'b0, "R8 pwr_up low", ser_oe, 0);
        repeat (3) @(negedge clk);
        #1;
        check({ser_oe, ser_out, sync_busy} == 3'b000, "R10 power-down",
              {ser_oe, ser_out, sync_busy}, 0);
        pwr_up = 1'b1;
        for (int i = 0; i < IL; i++) w_dark(DW'(i + 31), DW'(i + 77), "R10 reinit");
        w_data(10'h3A5, 10'h05A, "R10 data after reinit");
        w_data(10'h05A, 10'h3A5, "R10 data after reinit");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule